// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A processor programs it over a small byte-wide bus with active-low select, read and write strobes and a two-bit address. One write sets up a control word, which chooses the counting mode, the number format and the way count bytes are moved. Further writes then supply a 16-bit initial count. The channel counts on the falling edges of an external count clock. A gate input either enables counting or triggers it, and the result appears on a single output pin.

Four modes are supported: a terminal-count flag, a gate-triggered one-shot, a rate generator and a square-wave generator. Counting can be pure binary or four-digit decimal (BCD). Software can freeze a snapshot of the running count and read it back byte by byte while the counter keeps running. Both the count clock and the gate are asynchronous to the system clock. They are synchronised inside the block, and their edges are turned into one-cycle pulses.

Top module: `interval_counter`

## Requirements
- R1: After reset the output pin is low and the live count reads back as zero.
- R2: A control word is accepted only at address 3 with bits 7..6 equal to 00. A word with any other value in bits 7..6 (01, 10, or 11 for read-back) has no effect. So has a word whose mode field (bits 3..1) is 4 or 5.
- R3: Count bytes are written at address 0, and bits 5..4 of the control word choose the byte format: 01 writes the low byte only, 10 writes the high byte only (low byte cleared), 11 writes the low byte then the high byte. An initial count of 0 acts as 65536 in binary and as 10000 in BCD, so the first decrement gives 16'hFFFF or 16'h9999.
- R4: A count whose write is complete is moved into the counting element at the next count-clock falling edge. Each further falling edge moves it by one step.
- R5: Mode 0 (bits 3..1 = 000): the output stays low from the count write until the count reaches 0. It then goes high at that falling edge and stays high until the channel is reprogrammed.
- R6: Mode 1 (001): the output stays high after the count is written until a gate rising edge. At the next falling edge after that edge the count loads and the output goes low. It goes high again N edges later. A new gate rising edge retriggers the channel.
- R7: Mode 2 (010, also 110): the output is low for one count-clock period when the count is 1. At the following edge the initial count reloads, which gives a period of N edges.
- R8: Mode 3 (011, also 111): with an even N the output is high for N/2 periods and low for N/2. With an odd N it is high for (N+1)/2 periods and low for (N-1)/2. The pattern then repeats.
- R9: In modes 0, 2 and 3 a low gate level holds the count and the output. The load of a new count still happens while the gate is low.
- R10: With bit 0 of the control word set, the count decrements as four BCD digits with decimal borrow (0100 becomes 0099).
- R11: A control word with bits 5..4 = 00 latches the current count. The latched value is read until its last byte has been read. A second latch command given before then is ignored.
- R12: With byte format 11, reads at address 0 return the low byte and then the high byte. Formats 01 and 10 return only the low byte or only the high byte.
- R13: An accepted control word drives the output low for mode 0 and high for modes 1, 2 and 3, and it stops any count in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low bus select |
| rd_n | input | 1 | Active-low read strobe, one system cycle per byte |
| wr_n | input | 1 | Active-low write strobe, one system cycle per byte |
| addr | input | 2 | Register address: 0 count, 3 control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for address 0 |
| cnt_clk | input | 1 | External count clock, asynchronous |
| gate | input | 1 | Gate enable or trigger, asynchronous |
| out_pin | output | 1 | Channel output waveform |

## Verification
The counting modes are driven with initial counts drawn at random but forced to even and then odd parity. This separates the half-period split of the square wave from the single-period low pulse of the rate generator. Directed cases cover the count values at the edges: zero in binary and BCD, and 0100 in BCD, which tells decimal borrow apart from binary borrow. The three byte formats are also covered directly. Gate patterns tell a level hold apart from an edge trigger. Latch-then-count sequences show whether a read returns the frozen snapshot or the live value.

// File: rtl/pitc_pkg.sv
package pitc_pkg;

  localparam int PIT_CNT_W  = 16;
  localparam int PIT_DIGITS = PIT_CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LSB   = 2'b01,
    ACC_MSB   = 2'b10,
    ACC_BOTH  = 2'b11
  } access_e;

  typedef enum logic [1:0] {
    MD_TC      = 2'd0,
    MD_ONESHOT = 2'd1,
    MD_RATE    = 2'd2,
    MD_SQUARE  = 2'd3
  } mode_e;

  // Modes 4 and 5 are outside this channel; 6 and 7 alias 2 and 3.
  function automatic logic mode_ok(input logic [2:0] f);
    return !(f == 3'd4 || f == 3'd5);
  endfunction

  // One step down, binary or BCD with decimal borrow.
  function automatic logic [PIT_CNT_W-1:0] count_dec(
    input logic [PIT_CNT_W-1:0] v, input logic bcd);
    logic [PIT_CNT_W-1:0] r;
    logic borrow;
    logic [3:0] d;
    if (!bcd) return v - 1'b1;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < PIT_DIGITS; i++) begin
      d = v[i*4 +: 4];
      if (borrow) begin
        if (d == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = d - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Numeric weight of a count; zero stands for the full range.
  function automatic logic [31:0] count_value(
    input logic [PIT_CNT_W-1:0] v, input logic bcd);
    logic [31:0] acc;
    logic [31:0] scale;
    if (!bcd) return (v == '0) ? (32'd1 << PIT_CNT_W) : 32'(v);
    acc = 32'd0;
    scale = 32'd1;
    for (int i = 0; i < PIT_DIGITS; i++) begin
      acc = acc + 32'(v[i*4 +: 4]) * scale;
      scale = scale * 32'd10;
    end
    return (acc == 32'd0) ? scale : acc;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev_q & ~level;
    end else begin : g_rise
      assign pulse = ~prev_q & level;
    end
  endgenerate

  // R4: one edge of the input yields exactly one pulse
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/bus_regs.sv
module bus_regs
  import pitc_pkg::*;
#(
  parameter logic [1:0] CNT_ADDR  = 2'b00,
  parameter logic [1:0] CTRL_ADDR = 2'b11,
  parameter logic [1:0] CHAN_ID   = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [1:0]           addr,
  input  logic [7:0]           wdata,
  input  logic [PIT_CNT_W-1:0] live_cnt,
  output logic [7:0]           rdata,
  output mode_e                mode,
  output logic                 bcd,
  output logic [PIT_CNT_W-1:0] cr,
  output logic                 cfg_wr,
  output logic                 cr_done
);
  access_e              acc_q;
  mode_e                mode_q;
  logic                 bcd_q;
  logic                 wptr_q, rptr_q, latched_q;
  logic [PIT_CNT_W-1:0] cr_q, ol_q;
  logic                 cfg_wr_q, cr_done_q;

  logic wr_en, rd_en, ctrl_hit, is_latch, is_cfg, cnt_wr, rd_fire, rd_last, hi_sel;
  logic [PIT_CNT_W-1:0] src;

  assign wr_en    = !cs_n && !wr_n;
  assign rd_en    = !cs_n && !rd_n;
  assign ctrl_hit = wr_en && addr == CTRL_ADDR && wdata[7:6] == CHAN_ID;
  assign is_latch = ctrl_hit && wdata[5:4] == ACC_LATCH;
  assign is_cfg   = ctrl_hit && wdata[5:4] != ACC_LATCH && mode_ok(wdata[3:1]);
  assign cnt_wr   = wr_en && addr == CNT_ADDR;
  assign rd_fire  = rd_en && addr == CNT_ADDR;
  assign hi_sel   = (acc_q == ACC_MSB) || (acc_q == ACC_BOTH && rptr_q);
  assign rd_last  = rd_fire && (acc_q != ACC_BOTH || rptr_q);
  assign src      = latched_q ? ol_q : live_cnt;

  always_comb begin
    rdata = 8'h00;
    if (addr == CNT_ADDR) rdata = hi_sel ? src[PIT_CNT_W-1:8] : src[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_BOTH;
      mode_q    <= MD_TC;
      bcd_q     <= 1'b0;
      wptr_q    <= 1'b0;
      rptr_q    <= 1'b0;
      latched_q <= 1'b0;
      cr_q      <= '0;
      ol_q      <= '0;
      cfg_wr_q  <= 1'b0;
      cr_done_q <= 1'b0;
    end else begin
      cfg_wr_q  <= is_cfg;
      cr_done_q <= 1'b0;
      if (is_cfg) begin
        acc_q     <= access_e'(wdata[5:4]);
        mode_q    <= mode_e'(wdata[2:1]);
        bcd_q     <= wdata[0];
        wptr_q    <= 1'b0;
        rptr_q    <= 1'b0;
        latched_q <= 1'b0;
      end else begin
        if (is_latch && !latched_q) begin
          ol_q      <= live_cnt;
          latched_q <= 1'b1;
        end
        if (cnt_wr) begin
          unique case (acc_q)
            ACC_LSB: begin
              cr_q      <= {{(PIT_CNT_W-8){1'b0}}, wdata};
              cr_done_q <= 1'b1;
            end
            ACC_MSB: begin
              cr_q      <= {wdata, 8'h00};
              cr_done_q <= 1'b1;
            end
            ACC_BOTH: begin
              if (!wptr_q) cr_q[7:0] <= wdata;
              else begin
                cr_q[PIT_CNT_W-1:8] <= wdata;
                cr_done_q <= 1'b1;
              end
              wptr_q <= !wptr_q;
            end
            default: ;
          endcase
        end
        if (rd_fire) begin
          if (acc_q == ACC_BOTH) rptr_q <= !rptr_q;
          if (rd_last && latched_q) latched_q <= 1'b0;
        end
      end
    end
  end

  assign mode    = mode_q;
  assign bcd     = bcd_q;
  assign cr      = cr_q;
  assign cfg_wr  = cfg_wr_q;
  assign cr_done = cr_done_q;

  // R2: a word for another channel or for read-back leaves the setup alone
  assert_foreign_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR && wdata[7:6] != CHAN_ID)
      |=> ($stable(mode_q) && $stable(acc_q) && $stable(bcd_q)));

  // R11: the snapshot does not move until its last byte is read
  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !rd_last && !is_cfg) |=> $stable(ol_q));

endmodule

// File: rtl/count_core.sv
module count_core
  import pitc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_pulse,
  input  logic                 cnt_level,
  input  logic                 gate_level,
  input  logic                 gate_rise,
  input  mode_e                mode,
  input  logic                 bcd,
  input  logic [PIT_CNT_W-1:0] cr,
  input  logic                 cfg_wr,
  input  logic                 cr_done,
  output logic [PIT_CNT_W-1:0] ce,
  output logic                 out_level
);
  logic [PIT_CNT_W-1:0] ce_q, nrun_q;
  logic out_q, run_q, pend_q, armed_q, trig_q;

  logic                 at_one, step_en, sq_high;
  logic [PIT_CNT_W-1:0] dec_v, nrun_nx, cyc_nx;

  assign at_one  = (ce_q == PIT_CNT_W'(1));
  assign dec_v   = count_dec(ce_q, bcd);
  assign nrun_nx = at_one ? cr : nrun_q;
  assign cyc_nx  = at_one ? cr : dec_v;
  assign sq_high = count_value(cyc_nx, bcd) > (count_value(nrun_nx, bcd) >> 1);
  assign step_en = fall_pulse && run_q && !pend_q && gate_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      nrun_q  <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (cfg_wr) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      out_q   <= (mode != MD_TC);
    end else if (cr_done) begin
      armed_q <= 1'b1;
      if (mode != MD_ONESHOT) begin
        pend_q <= 1'b1;
        if (mode == MD_TC) begin
          out_q <= 1'b0;
          run_q <= 1'b0;
        end
      end
    end else if (mode == MD_ONESHOT) begin
      if (fall_pulse && trig_q) begin
        ce_q   <= cr;
        nrun_q <= cr;
        out_q  <= 1'b0;
        run_q  <= 1'b1;
        trig_q <= 1'b0;
      end else if (fall_pulse && run_q) begin
        ce_q <= dec_v;
        if (dec_v == '0) out_q <= 1'b1;
      end
      if (gate_rise && armed_q) trig_q <= 1'b1;
    end else begin
      if (fall_pulse && pend_q) begin
        ce_q   <= cr;
        nrun_q <= cr;
        run_q  <= 1'b1;
        pend_q <= 1'b0;
        out_q  <= (mode != MD_TC);
      end else if (step_en) begin
        if (mode == MD_TC) begin
          ce_q <= dec_v;
          if (dec_v == '0) out_q <= 1'b1;
        end else begin
          ce_q   <= cyc_nx;
          nrun_q <= nrun_nx;
          out_q  <= (mode == MD_RATE) ? (cyc_nx != PIT_CNT_W'(1)) : sq_high;
        end
      end
    end
  end

  assign ce        = ce_q;
  assign out_level = out_q;

  // R4: a counting step is only taken when the synchronised clock is low
  assert_fall_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> !cnt_level);

  // R5: once terminal count is flagged it holds until reprogramming
  assert_tc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TC && out_q && !cfg_wr && !cr_done) |=> out_q);

  // R7: the rate generator reloads the initial count after reaching one
  assert_rate_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode == MD_RATE && at_one && !cfg_wr && !cr_done)
      |=> (ce_q == $past(cr)));

  // R9: a low gate freezes the count in the level-gated modes
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode != MD_ONESHOT && !gate_level && !pend_q && !cfg_wr && !cr_done)
      |=> $stable(ce_q));

  // R13: a mode-0 word leaves the output low
  assert_mode0_word_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode == MD_TC) |=> !out_q);

endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import pitc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cnt_clk,
  input  logic       gate,
  output logic       out_pin
);
  logic                 cnt_level, cnt_fall, gate_level, gate_rise;
  logic [PIT_CNT_W-1:0] live_cnt, cr;
  mode_e                mode;
  logic                 bcd, cfg_wr, cr_done;

  edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_clk), .level(cnt_level), .pulse(cnt_fall));

  edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate), .level(gate_level), .pulse(gate_rise));

  bus_regs u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .live_cnt(live_cnt), .rdata(rdata),
    .mode(mode), .bcd(bcd), .cr(cr), .cfg_wr(cfg_wr), .cr_done(cr_done));

  count_core u_core (
    .clk(clk), .rst_n(rst_n), .fall_pulse(cnt_fall), .cnt_level(cnt_level),
    .gate_level(gate_level), .gate_rise(gate_rise), .mode(mode), .bcd(bcd),
    .cr(cr), .cfg_wr(cfg_wr), .cr_done(cr_done), .ce(live_cnt),
    .out_level(out_pin));

endmodule

// File: tb/interval_counter_tb.sv
`timescale 1ns/1ps
module interval_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cnt_clk = 1'b1;
  logic       gate = 1'b1;
  logic       out_pin;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  interval_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_clk(cnt_clk),
    .gate(gate), .out_pin(out_pin));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 2'b00;
    #2 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic prog(input int md, input bit bcd, input logic [1:0] acc);
    bus_wr(2'b11, {2'b00, acc, 3'(md), bcd});
  endtask

  task automatic load16(input logic [15:0] n);
    bus_wr(2'b00, n[7:0]);
    bus_wr(2'b00, n[15:8]);
  endtask

  task automatic latch_read(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_wr(2'b11, 8'h00);
    bus_rd(lo);
    bus_rd(hi);
    v = {hi, lo};
  endtask

  task automatic tick();
    cnt_clk = 1'b0;
    repeat (4) @(negedge clk);
    cnt_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_gate(input logic g);
    gate = g;
    repeat (4) @(negedge clk);
  endtask

  // expected count during a repeating mode, t ticks after the write
  function automatic int cyc_count(input int n, input int t);
    return n - ((t - 1) % n);
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int x;
    x = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int n;
    int unsigned seed_init;
    seed_init = $urandom(32'd7311);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out after reset", 32'(out_pin), 0);
    bus_rd(b);
    chk("R1 count low byte after reset", 32'(b), 0);

    // Mode 0, random count
    prog(0, 1'b0, 2'b11);
    chk("R13 mode0 word out", 32'(out_pin), 0);
    n = 2 + int'($urandom % 9);
    load16(16'(n));
    for (int t = 1; t <= n + 2; t++) begin
      tick();
      chk("R5 mode0 out", 32'(out_pin), 32'(t >= n + 1));
      if (t == 1) begin
        latch_read(v);
        chk("R4 R12 loaded count", 32'(v), 32'(n));
      end
      if (t == 2) begin
        latch_read(v);
        chk("R4 one step per edge", 32'(v), 32'(n - 1));
      end
    end

    // Mode 2, even then odd
    for (int k = 0; k < 2; k++) begin
      prog(2, 1'b0, 2'b11);
      chk("R13 mode2 word out", 32'(out_pin), 1);
      n = 2 * (1 + int'($urandom % 4)) + k + (k == 1 ? 0 : 0);
      if (n < 2) n = 2;
      load16(16'(n));
      for (int t = 1; t <= 3 * n + 1; t++) begin
        tick();
        chk("R7 rate out", 32'(out_pin), 32'(cyc_count(n, t) != 1));
      end
    end

    // Mode 3, even then odd
    for (int k = 0; k < 2; k++) begin
      prog(3, 1'b0, 2'b11);
      chk("R13 mode3 word out", 32'(out_pin), 1);
      n = 2 * (1 + int'($urandom % 5)) + k;
      load16(16'(n));
      for (int t = 1; t <= 2 * n + 1; t++) begin
        tick();
        chk("R8 square out", 32'(out_pin), 32'(cyc_count(n, t) > n / 2));
      end
    end

    // Mode 1 one-shot
    set_gate(1'b0);
    prog(1, 1'b0, 2'b11);
    chk("R13 mode1 word out", 32'(out_pin), 1);
    n = 3 + int'($urandom % 6);
    load16(16'(n));
    for (int t = 0; t < 3; t++) begin
      tick();
      chk("R6 no trigger yet", 32'(out_pin), 1);
    end
    set_gate(1'b1);
    for (int u = 1; u <= n + 2; u++) begin
      tick();
      chk("R6 one-shot out", 32'(out_pin), 32'(u >= n + 1));
    end
    set_gate(1'b0);
    set_gate(1'b1);
    tick();
    chk("R6 retrigger out low", 32'(out_pin), 0);

    // Gate hold in mode 0
    prog(0, 1'b0, 2'b11);
    load16(16'd6);
    tick();
    set_gate(1'b0);
    repeat (5) tick();
    chk("R9 out held", 32'(out_pin), 0);
    latch_read(v);
    chk("R9 count held", 32'(v), 6);
    set_gate(1'b1);
    repeat (5) tick();
    chk("R9 resumed not done", 32'(out_pin), 0);
    tick();
    chk("R9 resumed done", 32'(out_pin), 1);

    // BCD
    prog(0, 1'b1, 2'b11);
    load16(16'h0100);
    tick(); tick();
    latch_read(v);
    chk("R10 decimal borrow", 32'(v), 32'h0099);
    load16(16'h0000);
    tick(); tick();
    latch_read(v);
    chk("R3 R10 bcd zero", 32'(v), 32'h9999);
    load16(to_bcd(12));
    for (int t = 1; t <= 13; t++) begin
      tick();
      if (t >= 12) chk("R10 bcd terminal", 32'(out_pin), 32'(t >= 13));
    end
    prog(0, 1'b0, 2'b11);
    load16(16'h0000);
    tick(); tick();
    latch_read(v);
    chk("R3 binary zero", 32'(v), 32'hFFFF);

    // Byte formats
    prog(0, 1'b0, 2'b10);
    bus_wr(2'b00, 8'h01);
    tick();
    bus_rd(b);
    chk("R3 R12 msb only", 32'(b), 32'h01);
    tick();
    bus_rd(b);
    chk("R3 R12 msb after borrow", 32'(b), 32'h00);
    prog(0, 1'b0, 2'b01);
    bus_wr(2'b00, 8'h05);
    repeat (5) tick();
    chk("R3 lsb only not done", 32'(out_pin), 0);
    tick();
    chk("R3 lsb only done", 32'(out_pin), 1);
    bus_rd(b);
    chk("R12 lsb only read", 32'(b), 32'h00);

    // Latch hold
    prog(0, 1'b0, 2'b11);
    load16(16'd40);
    repeat (3) tick();
    bus_wr(2'b11, 8'h00);
    repeat (2) tick();
    bus_wr(2'b11, 8'h00);
    tick();
    bus_rd(b); v[7:0] = b;
    bus_rd(b); v[15:8] = b;
    chk("R11 snapshot kept", 32'(v), 38);
    bus_rd(b); v[7:0] = b;
    bus_rd(b); v[15:8] = b;
    chk("R11 live after read", 32'(v), 35);

    // Ignored words
    prog(2, 1'b0, 2'b11);
    load16(16'd4);
    tick(); tick();
    bus_wr(2'b11, 8'h70);
    chk("R2 other channel ignored", 32'(out_pin), 1);
    bus_wr(2'b11, 8'hF0);
    bus_wr(2'b11, 8'h38);
    chk("R2 readback and mode4 ignored", 32'(out_pin), 1);
    tick();
    chk("R2 rate continues high", 32'(out_pin), 1);
    tick();
    chk("R2 rate continues low", 32'(out_pin), 0);
    tick();
    chk("R2 rate reload high", 32'(out_pin), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule